// File: doc/BRIEF.md
# Prioritized Interrupt Dispatch Unit

This block decides, one request at a time, whether a pending interrupt level is accepted by the processor. When it is, the block updates the return-state registers it owns and reports the new status word, the next fetch address and the class of event. A level is accepted only if it is above the current interrupt level and within the configured number of levels. At least one interrupt line of that level must also be both raised and enabled. The level-to-line assignment comes from a per-level mask table.

Levels above 1 save the PC and status word into their own return registers, raise the status interrupt level to the accepted level, set exception mode and jump to that level's vector. Level 1 is turned into an ordinary exception instead. The block records the level-1 cause code and chooses a user, kernel or double exception from the exception-mode and user-mode bits of the status word. When vector relocation is enabled, every target is moved by the distance between the vector-base input and the default base.

Top module: `irq_dispatch`

## Requirements
- R1: A request (`reqValid` high) is accepted only if `pendLevel` is strictly greater than `curLevel`.
- R2: A request is accepted only if `pendLevel` is between 1 and `NUM_LEVELS`. Level 0 and levels above `NUM_LEVELS` are never accepted.
- R3: A request is accepted only if `levelMask[pendLevel] & intSet & intEnable` is nonzero. `levelMask[L]` is bits `[L*NUM_IRQ +: NUM_IRQ]` of `levelMaskFlat`.
- R4: `takenOut` is high for exactly the one cycle after the edge that samples an accepted request, and all other outputs change at that same edge. A refused request, or a cycle with `reqValid` low, changes no output.
- R5: For an accepted level L above 1, saved-PC L (`epcFlat[(L-1)*32 +: 32]`) takes `pc`, and saved-status L (`epsFlat[(L-2)*32 +: 32]`) takes `psIn`.
- R6: For an accepted level L above 1, `psOut` is `psIn` with bits [3:0] replaced by L and bit `EXCM_BIT` set. `excClassOut` is 4, and the vector offset is 0x400 + 0x40*L. The cause register is left unchanged.
- R7: For an accepted level 1 with exception mode (`psIn[EXCM_BIT]`) clear, saved-PC 1 takes `pc`, `excCauseOut` takes `LEVEL1_CAUSE`, and `psOut` is `psIn` with `EXCM_BIT` set. With `psIn[UM_BIT]` set the class is 1 (user) at offset 0x340; otherwise it is 2 (kernel) at offset 0x300.
- R8: For an accepted level 1 with exception mode already set, the class is 3 (double) at offset 0x3C0, and the cause and status are updated as in R7. With `HAS_DEPC` the PC goes to `depcOut` and saved-PC 1 is left unchanged; without `HAS_DEPC` it goes to saved-PC 1.
- R9: With `RELOC_EN`, `nextPcOut` = (`DEFAULT_VECBASE` + offset) - `DEFAULT_VECBASE` + `vecBase`. Without `RELOC_EN` it is `DEFAULT_VECBASE` + offset.
- R10: After reset every output is zero and `excClassOut` is 0 (none).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Evaluate the pending level this cycle |
| pendLevel | input | 4 | Pending interrupt level |
| curLevel | input | 4 | Current interrupt level |
| intSet | input | NUM_IRQ | Raised interrupt lines |
| intEnable | input | NUM_IRQ | Enabled interrupt lines |
| levelMaskFlat | input | (NUM_LEVELS+1)*NUM_IRQ | Line mask for each level 0..NUM_LEVELS |
| pc | input | 32 | Current program counter |
| psIn | input | 32 | Current status word |
| vecBase | input | 32 | Vector base register |
| takenOut | output | 1 | One-cycle accepted pulse |
| excClassOut | output | 3 | 0 none, 1 user, 2 kernel, 3 double, 4 high level |
| nextPcOut | output | 32 | Target vector address |
| psOut | output | 32 | New status word |
| excCauseOut | output | CAUSE_W | Exception cause register |
| depcOut | output | 32 | Double-exception saved PC |
| epcFlat | output | NUM_LEVELS*32 | Saved-PC registers for levels 1..NUM_LEVELS |
| epsFlat | output | (NUM_LEVELS-1)*32 | Saved-status registers for levels 2..NUM_LEVELS |

## Verification
Each vector row is applied and then checked against a shadow model of every return register. The rows include a level equal to the current level, a level past the configured count, level 0, and lines raised but disabled. They also include a line raised at the wrong level. Each of these isolates one term of the acceptance test. Level-1 rows vary the user-mode and exception-mode bits, which separates the user, kernel and double paths and the destination of the saved PC. Two high-level rows use different levels, one of them through a line shared into a level's mask, which tells the per-level register selection apart. Directed runs change the vector base to expose the relocation arithmetic, hold `reqValid` low with qualifying inputs, and check the width of the accepted pulse.

// File: rtl/irq_dispatch_pkg.sv
package irq_dispatch_pkg;

  localparam int LEVEL_W = 4;

  typedef enum logic [2:0] {
    CLS_NONE   = 3'd0,
    CLS_USER   = 3'd1,
    CLS_KERNEL = 3'd2,
    CLS_DOUBLE = 3'd3,
    CLS_HIGH   = 3'd4
  } exc_class_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       take;
    logic       high;
    logic       wrEpc1;
    logic       wrDepc;
    logic       wrCause;
    exc_class_e cls;
  } disp_strobe_t;

  function automatic logic [31:0] vecOffset(input exc_class_e cls,
                                            input logic [LEVEL_W-1:0] lvl);
    logic [31:0] off;
    case (cls)
      CLS_USER:   off = 32'h340;
      CLS_KERNEL: off = 32'h300;
      CLS_DOUBLE: off = 32'h3C0;
      CLS_HIGH:   off = 32'h400 + ({28'd0, lvl} << 6);
      default:    off = 32'h0;
    endcase
    return off;
  endfunction

endpackage

// File: rtl/irq_dispatch_ctrl.sv
module irq_dispatch_ctrl
  import irq_dispatch_pkg::*;
#(
  parameter int NUM_IRQ    = 8,
  parameter int NUM_LEVELS = 6,
  parameter bit HAS_DEPC   = 1'b1
) (
  input  logic                             reqValid,
  input  logic [LEVEL_W-1:0]               pendLevel,
  input  logic [LEVEL_W-1:0]               curLevel,
  input  logic [NUM_IRQ-1:0]               intSet,
  input  logic [NUM_IRQ-1:0]               intEnable,
  input  logic [(NUM_LEVELS+1)*NUM_IRQ-1:0] levelMaskFlat,
  input  logic                             excmBit,
  input  logic                             umBit,
  output disp_strobe_t                     strobe
);

  localparam int MASK_W = (NUM_LEVELS + 1) * NUM_IRQ;
  localparam logic [LEVEL_W-1:0] MAX_LVL = LEVEL_W'(NUM_LEVELS);

  logic [NUM_LEVELS:0] lvlHit;
  logic [NUM_IRQ-1:0]  liveLines;
  logic                maskHit;
  logic                inRange;
  logic                aboveCur;
  logic                qualified;

  assign liveLines = intSet & intEnable;

  genvar g;
  generate
    for (g = 0; g <= NUM_LEVELS; g++) begin : g_lvl
      assign lvlHit[g] = |(levelMaskFlat[g*NUM_IRQ +: NUM_IRQ] & liveLines);
    end
  endgenerate

  always_comb begin
    maskHit = 1'b0;
    for (int l = 0; l <= NUM_LEVELS; l++) begin
      if (pendLevel == LEVEL_W'(l)) maskHit = lvlHit[l];
    end
  end

  assign inRange   = (pendLevel != '0) && (pendLevel <= MAX_LVL);
  assign aboveCur  = pendLevel > curLevel;
  assign qualified = reqValid && inRange && aboveCur && maskHit;

  always_comb begin
    strobe         = '0;
    strobe.cls     = CLS_NONE;
    strobe.take    = qualified;
    if (qualified) begin
      if (pendLevel > LEVEL_W'(1)) begin
        strobe.high = 1'b1;
        strobe.cls  = CLS_HIGH;
      end else begin
        strobe.wrCause = 1'b1;
        if (excmBit) begin
          strobe.cls    = CLS_DOUBLE;
          strobe.wrDepc = HAS_DEPC;
          strobe.wrEpc1 = !HAS_DEPC;
        end else begin
          strobe.wrEpc1 = 1'b1;
          strobe.cls    = umBit ? CLS_USER : CLS_KERNEL;
        end
      end
    end
  end

  initial begin
    assert (NUM_LEVELS >= 2 && NUM_LEVELS <= 15 && MASK_W > 0)
      else $error("AST_LEVEL_RANGE: NUM_LEVELS out of range"); // R2
  end

endmodule

// File: rtl/irq_dispatch_dp.sv
module irq_dispatch_dp
  import irq_dispatch_pkg::*;
#(
  parameter int          NUM_LEVELS      = 6,
  parameter int          CAUSE_W         = 6,
  parameter int          EXCM_BIT        = 4,
  parameter logic [5:0]  LEVEL1_CAUSE    = 6'd4,
  parameter bit          RELOC_EN        = 1'b1,
  parameter logic [31:0] DEFAULT_VECBASE = 32'h4000_0000
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  disp_strobe_t                 strobe,
  input  logic [LEVEL_W-1:0]           pendLevel,
  input  logic [31:0]                  pc,
  input  logic [31:0]                  psIn,
  input  logic [31:0]                  vecBase,
  output logic                         takenOut,
  output logic [2:0]                   excClassOut,
  output logic [31:0]                  nextPcOut,
  output logic [31:0]                  psOut,
  output logic [CAUSE_W-1:0]           excCauseOut,
  output logic [31:0]                  depcOut,
  output logic [NUM_LEVELS*32-1:0]     epcFlat,
  output logic [(NUM_LEVELS-1)*32-1:0] epsFlat
);

  localparam logic [31:0] EXCM_MASK = 32'h1 << EXCM_BIT;

  logic [31:0] fixedVec;
  logic [31:0] targetVec;
  logic [31:0] psNew;

  assign fixedVec = DEFAULT_VECBASE + vecOffset(strobe.cls, pendLevel);

  generate
    if (RELOC_EN) begin : g_reloc
      assign targetVec = fixedVec - DEFAULT_VECBASE + vecBase;
    end else begin : g_fixed
      logic [31:0] unusedBase;
      assign unusedBase = vecBase;
      assign targetVec  = fixedVec;
    end
  endgenerate

  always_comb begin
    if (strobe.high) psNew = {psIn[31:LEVEL_W], pendLevel} | EXCM_MASK;
    else             psNew = psIn | EXCM_MASK;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      takenOut    <= 1'b0;
      excClassOut <= CLS_NONE;
      nextPcOut   <= '0;
      psOut       <= '0;
      excCauseOut <= '0;
      depcOut     <= '0;
    end else begin
      takenOut <= strobe.take;
      if (strobe.take) begin
        excClassOut <= strobe.cls;
        nextPcOut   <= targetVec;
        psOut       <= psNew;
      end
      if (strobe.take && strobe.wrCause) excCauseOut <= LEVEL1_CAUSE[CAUSE_W-1:0];
      if (strobe.take && strobe.wrDepc)  depcOut     <= pc;
    end
  end

  genvar g;
  generate
    for (g = 1; g <= NUM_LEVELS; g++) begin : g_epc
      logic wrThis;
      assign wrThis = strobe.take &&
                      ((strobe.high && pendLevel == LEVEL_W'(g)) ||
                       (g == 1 && strobe.wrEpc1));
      always_ff @(posedge clk) begin
        if (!rstN)       epcFlat[(g-1)*32 +: 32] <= '0;
        else if (wrThis) epcFlat[(g-1)*32 +: 32] <= pc;
      end
    end
    for (g = 2; g <= NUM_LEVELS; g++) begin : g_eps
      always_ff @(posedge clk) begin
        if (!rstN) epsFlat[(g-2)*32 +: 32] <= '0;
        else if (strobe.take && strobe.high && pendLevel == LEVEL_W'(g))
          epsFlat[(g-2)*32 +: 32] <= psIn;
      end
    end
  endgenerate

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !takenOut |-> $stable(nextPcOut) && $stable(psOut) && $stable(excClassOut)) // R4
    else $error("AST_HOLD_WHEN_IDLE");
  AST_HIGH_SETS_EXCM: assert property (@(posedge clk) disable iff (!rstN)
    (takenOut && excClassOut == CLS_HIGH) |-> psOut[EXCM_BIT] && psOut[LEVEL_W-1:0] > 4'd1) // R6
    else $error("AST_HIGH_SETS_EXCM");
  AST_CAUSE_ONLY_L1: assert property (@(posedge clk) disable iff (!rstN)
    (takenOut && excClassOut == CLS_HIGH) |-> $stable(excCauseOut)) // R6
    else $error("AST_CAUSE_ONLY_L1");

endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
  import irq_dispatch_pkg::*;
#(
  parameter int          NUM_IRQ         = 8,
  parameter int          NUM_LEVELS      = 6,
  parameter int          CAUSE_W         = 6,
  parameter int          EXCM_BIT        = 4,
  parameter int          UM_BIT          = 5,
  parameter logic [5:0]  LEVEL1_CAUSE    = 6'd4,
  parameter bit          HAS_DEPC        = 1'b1,
  parameter bit          RELOC_EN        = 1'b1,
  parameter logic [31:0] DEFAULT_VECBASE = 32'h4000_0000
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              reqValid,
  input  logic [3:0]                        pendLevel,
  input  logic [3:0]                        curLevel,
  input  logic [NUM_IRQ-1:0]                intSet,
  input  logic [NUM_IRQ-1:0]                intEnable,
  input  logic [(NUM_LEVELS+1)*NUM_IRQ-1:0] levelMaskFlat,
  input  logic [31:0]                       pc,
  input  logic [31:0]                       psIn,
  input  logic [31:0]                       vecBase,
  output logic                              takenOut,
  output logic [2:0]                        excClassOut,
  output logic [31:0]                       nextPcOut,
  output logic [31:0]                       psOut,
  output logic [CAUSE_W-1:0]                excCauseOut,
  output logic [31:0]                       depcOut,
  output logic [NUM_LEVELS*32-1:0]          epcFlat,
  output logic [(NUM_LEVELS-1)*32-1:0]      epsFlat
);

  disp_strobe_t strobe;

  irq_dispatch_ctrl #(
    .NUM_IRQ   (NUM_IRQ),
    .NUM_LEVELS(NUM_LEVELS),
    .HAS_DEPC  (HAS_DEPC)
  ) u_ctrl (
    .reqValid     (reqValid),
    .pendLevel    (pendLevel),
    .curLevel     (curLevel),
    .intSet       (intSet),
    .intEnable    (intEnable),
    .levelMaskFlat(levelMaskFlat),
    .excmBit      (psIn[EXCM_BIT]),
    .umBit        (psIn[UM_BIT]),
    .strobe       (strobe)
  );

  irq_dispatch_dp #(
    .NUM_LEVELS     (NUM_LEVELS),
    .CAUSE_W        (CAUSE_W),
    .EXCM_BIT       (EXCM_BIT),
    .LEVEL1_CAUSE   (LEVEL1_CAUSE),
    .RELOC_EN       (RELOC_EN),
    .DEFAULT_VECBASE(DEFAULT_VECBASE)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .pendLevel  (pendLevel),
    .pc         (pc),
    .psIn       (psIn),
    .vecBase    (vecBase),
    .takenOut   (takenOut),
    .excClassOut(excClassOut),
    .nextPcOut  (nextPcOut),
    .psOut      (psOut),
    .excCauseOut(excCauseOut),
    .depcOut    (depcOut),
    .epcFlat    (epcFlat),
    .epsFlat    (epsFlat)
  );

  AST_TAKE_ABOVE_CUR: assert property (@(posedge clk) disable iff (!rstN)
    takenOut |-> $past(pendLevel) > $past(curLevel)) // R1
    else $error("AST_TAKE_ABOVE_CUR");
  AST_TAKE_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    takenOut |-> ($past(pendLevel) != 4'd0 && $past(pendLevel) <= 4'(NUM_LEVELS))) // R2
    else $error("AST_TAKE_IN_RANGE");
  AST_TAKE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    !$past(reqValid) |-> !takenOut) // R4
    else $error("AST_TAKE_NEEDS_REQ");
  AST_DOUBLE_FROM_EXCM: assert property (@(posedge clk) disable iff (!rstN)
    (takenOut && excClassOut == CLS_DOUBLE) |->
      ($past(psIn[EXCM_BIT]) && $past(pendLevel) == 4'd1)) // R8
    else $error("AST_DOUBLE_FROM_EXCM");

endmodule

// File: tb/irq_dispatch_tb.sv
`timescale 1ns/1ps
module irq_dispatch_tb;

  localparam int NUM_IRQ    = 8;
  localparam int NUM_LEVELS = 6;
  localparam int CAUSE_W    = 6;
  localparam int NUM_VEC    = 11;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [3:0] pendLevel = '0, curLevel = '0;
  logic [NUM_IRQ-1:0] intSet = '0, intEnable = '0;
  logic [(NUM_LEVELS+1)*NUM_IRQ-1:0] levelMaskFlat;
  logic [31:0] pc = '0, psIn = '0, vecBase = '0;
  logic takenOut;
  logic [2:0] excClassOut;
  logic [31:0] nextPcOut, psOut, depcOut;
  logic [CAUSE_W-1:0] excCauseOut;
  logic [NUM_LEVELS*32-1:0] epcFlat;
  logic [(NUM_LEVELS-1)*32-1:0] epsFlat;

  always #2.5 clk = ~clk;

  irq_dispatch u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .pendLevel(pendLevel),
    .curLevel(curLevel), .intSet(intSet), .intEnable(intEnable),
    .levelMaskFlat(levelMaskFlat), .pc(pc), .psIn(psIn), .vecBase(vecBase),
    .takenOut(takenOut), .excClassOut(excClassOut), .nextPcOut(nextPcOut),
    .psOut(psOut), .excCauseOut(excCauseOut), .depcOut(depcOut),
    .epcFlat(epcFlat), .epsFlat(epsFlat)
  );

  // level L owns line L-1; line 7 additionally belongs to level 3
  assign levelMaskFlat = {8'h20, 8'h10, 8'h08, 8'h84, 8'h02, 8'h01, 8'h00};

  // {pend, cur, set, en, ps, expTaken, expClass}
  localparam logic [59:0] VEC [NUM_VEC] = '{
    {4'd3, 4'd0, 8'h04, 8'h04, 32'h0000_0000, 1'b1, 3'd4}, // R5 R6 level 3
    {4'd3, 4'd3, 8'h04, 8'h04, 32'h0000_0000, 1'b0, 3'd0}, // R1 equal level
    {4'd7, 4'd0, 8'hFF, 8'hFF, 32'h0000_0000, 1'b0, 3'd0}, // R2 above count
    {4'd2, 4'd0, 8'h02, 8'h00, 32'h0000_0000, 1'b0, 3'd0}, // R3 disabled
    {4'd1, 4'd0, 8'h01, 8'h01, 32'h0000_0020, 1'b1, 3'd1}, // R7 user
    {4'd1, 4'd0, 8'h01, 8'h01, 32'h0000_0000, 1'b1, 3'd2}, // R7 kernel
    {4'd1, 4'd0, 8'h01, 8'h01, 32'h0000_0010, 1'b1, 3'd3}, // R8 double
    {4'd6, 4'd5, 8'h20, 8'h20, 32'hA5A5_0035, 1'b1, 3'd4}, // R6 level 6
    {4'd3, 4'd2, 8'h80, 8'h80, 32'h0000_0102, 1'b1, 3'd4}, // R3 shared line
    {4'd0, 4'd0, 8'hFF, 8'hFF, 32'h0000_0000, 1'b0, 3'd0}, // R2 level 0
    {4'd4, 4'd0, 8'h04, 8'h04, 32'h0000_0000, 1'b0, 3'd0}  // R3 wrong level
  };

  int nChecks = 0;
  int nFails  = 0;

  logic [31:0] expEpc [1:NUM_LEVELS];
  logic [31:0] expEps [2:NUM_LEVELS];
  logic [31:0] expDepc, expPs, expNext;
  logic [CAUSE_W-1:0] expCause;
  logic [2:0] expCls;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] offsetOf(input logic [2:0] cls, input logic [3:0] lvl);
    case (cls)
      3'd1: return 32'h340;
      3'd2: return 32'h300;
      3'd3: return 32'h3C0;
      3'd4: return 32'h400 + 32'h40 * lvl;
      default: return 32'h0;
    endcase
  endfunction

  task automatic modelTake(input logic [2:0] cls);
    expCls  = cls;
    expNext = vecBase + offsetOf(cls, pendLevel);
    if (cls == 3'd4) begin
      expEpc[pendLevel] = pc;
      expEps[pendLevel] = psIn;
      expPs = {psIn[31:4], pendLevel} | 32'h10;
    end else begin
      expPs    = psIn | 32'h10;
      expCause = 6'd4;
      if (cls == 3'd3) expDepc = pc;
      else             expEpc[1] = pc;
    end
  endtask

  task automatic checkAll(input string req);
    chk(req, "class", {29'd0, excClassOut}, {29'd0, expCls});
    chk(req, "nextPc", nextPcOut, expNext);
    chk(req, "ps", psOut, expPs);
    chk(req, "cause", {26'd0, excCauseOut}, {26'd0, expCause});
    chk(req, "depc", depcOut, expDepc);
    for (int l = 1; l <= NUM_LEVELS; l++) chk(req, "epc", epcFlat[(l-1)*32 +: 32], expEpc[l]);
    for (int l = 2; l <= NUM_LEVELS; l++) chk(req, "eps", epsFlat[(l-2)*32 +: 32], expEps[l]);
  endtask

  task automatic pulse();
    @(negedge clk); reqValid = 1'b1;
    @(negedge clk); reqValid = 1'b0;
  endtask

  initial begin : watchdog
    #500000;
    nFails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    for (int l = 1; l <= NUM_LEVELS; l++) expEpc[l] = '0;
    for (int l = 2; l <= NUM_LEVELS; l++) expEps[l] = '0;
    expDepc = '0; expPs = '0; expNext = '0; expCause = '0; expCls = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10", "taken", {31'd0, takenOut}, 32'd0);
    checkAll("R10");

    vecBase = 32'h6000_0000;
    for (int i = 0; i < NUM_VEC; i++) begin
      @(negedge clk);
      {pendLevel, curLevel, intSet, intEnable, psIn} = VEC[i][59:4];
      pc = 32'h1000_0000 + 32'(i) * 32'h10;
      reqValid = 1'b1;
      @(negedge clk);
      reqValid = 1'b0;
      if (VEC[i][3]) modelTake(VEC[i][2:0]);
      chk("R4", "taken", {31'd0, takenOut}, {31'd0, VEC[i][3]});
      checkAll(VEC[i][3] ? "R5-7" : "R1/R2/R3");
    end

    // R4 pulse lasts one cycle
    @(negedge clk);
    chk("R4", "pulse end", {31'd0, takenOut}, 32'd0);

    // R4 qualifying inputs with reqValid low change nothing
    pendLevel = 4'd5; curLevel = 4'd0; intSet = 8'h10; intEnable = 8'h10;
    psIn = 32'h0; pc = 32'hDEAD_0000;
    repeat (2) @(negedge clk);
    chk("R4", "no req taken", {31'd0, takenOut}, 32'd0);
    checkAll("R4");

    // R9 relocation with another base, level 5
    vecBase = 32'h2000_1000;
    pulse();
    modelTake(3'd4);
    chk("R9", "taken", {31'd0, takenOut}, 32'd1);
    chk("R9", "reloc target", nextPcOut, 32'h2000_1000 + 32'h400 + 32'h40 * 5);
    checkAll("R9");

    // R8 double exception leaves saved-PC 1 alone, uses new base
    pendLevel = 4'd1; intSet = 8'h01; intEnable = 8'h01; psIn = 32'h0000_0031;
    pc = 32'hCAFE_0004;
    pulse();
    modelTake(3'd3);
    chk("R8", "depc", depcOut, 32'hCAFE_0004);
    checkAll("R8");

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule